// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is the register-side half of an 8-bit general-purpose I/O port. A CPU writes a direction register, an output latch, a per-bit pull-up enable register and an option register through a small address/strobe bus. The block turns that state into per-pin output-enable, output-data and pull-up-enable signals for the pad models. Pin levels come back through a two-flop synchronizer and are read through the same port address.

One bit position, set by the `RST_BIT` parameter (default 5), is input-only. A configuration input can give that pin over to an external reset function. Two extra write addresses set or clear chosen latch bits. Both are read-modify-write: the current port read value is taken, changed and written back as a whole byte.

The address decode is an enumerated register select, resolved with a unique case: PORT (0), DIR (1), PUEN (2), OPT (3), BSET (4), BCLR (5). Codes 6 and 7 are unused.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A DIR bit of 1 turns off the pin's `pad_oe`. A DIR bit of 0 turns on `pad_oe`, and `pad_out` always carries the output latch.
- R2: A bus read of address 0 returns the pin levels after two synchronizer flops. A pin change driven between edges shows up on the read at the second falling edge, not at the first.
- R3: A write to address 0 stores `bus_wdata` in the output latch. Addresses 1, 2 and 3 read back DIR, PUEN and the option bit (bit 0).
- R4: Pin `RST_BIT` is never driven: its `pad_oe` stays 0 whatever its DIR bit holds.
- R5: While `rst_pin_mode` is 1, bit `RST_BIT` of the port read value is 0.
- R6: `pad_pu[i]` for an ordinary pin is 1 only when its PUEN bit is 1, its DIR bit is 1 and the global disable is clear. It is therefore always 0 on an output pin.
- R7: Option bit 0 (address 3) is an active-low pull-up enable. While it holds 1, every `pad_pu` bit is 0.
- R8: The pull-up of pin `RST_BIT` ignores its PUEN bit. It is on in reset mode and off in GPIO mode, subject only to the global disable.
- R9: A write to address 4 loads the latch with (port read value OR data). A write to address 5 loads it with (port read value AND NOT data).
- R10: After reset, DIR reads 0xFF, PUEN reads 0x00, the option bit reads 1 and the latch is 0x00, so `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R11: Writes to addresses 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rst_pin_mode | input | 1 | 1 = pin RST_BIT serves as external reset |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output data |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
The pad outputs and the port read are tried with six configurations. These cover all inputs, all outputs, split nibbles, a mixed pattern with the reset pin in reset mode, and a DIR value that tries to drive the input-only pin. Between them they separate the direction gating of pull-ups from the global disable, and the reset-pin pull-up rule from its enable bit. They also separate latch-sourced from pin-sourced read bits. Directed tests follow. One checks synchronizer latency edge by edge. Others run set and clear writes where an input pin's level is folded into the latch, then repeat them with the reset pin masked, so a plain latch-based update is told apart from a true read-modify-write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT = 3'd0,
        REG_DIR  = 3'd1,
        REG_PUEN = 3'd2,
        REG_OPT  = 3'd3,
        REG_BSET = 3'd4,
        REG_BCLR = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      port_view,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      puen_q,
    output logic              pu_off_q,
    output logic [W-1:0]      bus_rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '1;
            latch_q  <= '0;
            puen_q   <= '0;
            pu_off_q <= 1'b1;
        end else if (bus_wr) begin
            unique case (sel)
                REG_PORT: latch_q  <= bus_wdata;
                REG_DIR:  dir_q    <= bus_wdata;
                REG_PUEN: puen_q   <= bus_wdata;
                REG_OPT:  pu_off_q <= bus_wdata[0];
                REG_BSET: latch_q  <= port_view | bus_wdata;
                REG_BCLR: latch_q  <= port_view & ~bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_PORT: bus_rdata = port_view;
            REG_DIR:  bus_rdata = dir_q;
            REG_PUEN: bus_rdata = puen_q;
            REG_OPT:  bus_rdata = {{(W-1){1'b0}}, pu_off_q};
            default:  bus_rdata = '0;
        endcase
    end

    // R3
    port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_PORT) |=> latch_q == $past(bus_wdata));

    // R9
    bset_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_BSET) |=> latch_q == ($past(port_view) | $past(bus_wdata)));

    // R9
    bclr_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_BCLR) |=> latch_q == ($past(port_view) & ~$past(bus_wdata)));

    // R11
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > 3'd5) |=>
            ($stable(latch_q) && $stable(dir_q) && $stable(puen_q) && $stable(pu_off_q)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int W       = 8,
    parameter int RST_BIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] puen_q,
    input  logic         pu_off_q,
    input  logic         rst_pin_mode,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    assign pad_out = latch_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == RST_BIT) begin : g_rst
            assign pad_oe[i] = 1'b0;
            assign pad_pu[i] = rst_pin_mode & ~pu_off_q;
        end else begin : g_io
            assign pad_oe[i] = ~dir_q[i];
            assign pad_pu[i] = puen_q[i] & dir_q[i] & ~pu_off_q;

            // R6
            out_no_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pad_oe[i] |-> !pad_pu[i]);
        end
    end

    // R4
    rst_pin_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_q[RST_BIT] |-> !pad_oe[RST_BIT]);

    // R7
    global_pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_off_q |-> pad_pu == '0);

    // R8
    rst_pu_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (puen_q[RST_BIT] && !rst_pin_mode) |-> !pad_pu[RST_BIT]);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int W           = 8,
    parameter int RST_BIT     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              rst_pin_mode,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu
);
    localparam logic [W-1:0] RST_MASK = W'(1) << RST_BIT;

    logic [W-1:0] pin_sync;
    logic [W-1:0] port_view;
    logic [W-1:0] dir_q, latch_q, puen_q;
    logic         pu_off_q;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    assign port_view = rst_pin_mode ? (pin_sync & ~RST_MASK) : pin_sync;

    gpio_regfile #(.W(W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .port_view (port_view),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .puen_q    (puen_q),
        .pu_off_q  (pu_off_q),
        .bus_rdata (bus_rdata)
    );

    gpio_pad_ctrl #(.W(W), .RST_BIT(RST_BIT)) pads_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dir_q        (dir_q),
        .latch_q      (latch_q),
        .puen_q       (puen_q),
        .pu_off_q     (pu_off_q),
        .rst_pin_mode (rst_pin_mode),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pad_pu       (pad_pu)
    );

    // R5
    rst_pin_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_mode |-> !port_view[RST_BIT]);

    // R2
    read_tracks_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pin_mode && bus_addr == 3'd0) |-> bus_rdata == pin_sync);
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rst_pin_mode = 1'b0;
    logic [7:0] ext = '0;
    logic [7:0] pin_in;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    assign pin_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_pin_mode(rst_pin_mode),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    typedef struct packed {
        logic [7:0] dir, lat, pue;
        logic       puoff, rstm;
        logic [7:0] ext, e_oe, e_pu, e_rd;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 8'hA5, 8'h00, 8'h00, 8'hA5},
        '{8'h00, 8'h3C, 8'hFF, 1'b0, 1'b0, 8'h00, 8'hDF, 8'h00, 8'h1C},
        '{8'hF0, 8'h0F, 8'hFF, 1'b0, 1'b1, 8'hF0, 8'h0F, 8'hF0, 8'hDF},
        '{8'h0F, 8'hAA, 8'h0F, 1'b1, 1'b1, 8'h55, 8'hD0, 8'h00, 8'h85},
        '{8'hDF, 8'hFF, 8'h20, 1'b0, 1'b0, 8'h20, 8'h00, 8'h00, 8'h20},
        '{8'hFF, 8'h00, 8'h5A, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h5A, 8'hFF}
    };

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 oe", pad_oe, 8'h00);
        check("R10 out", pad_out, 8'h00);
        check("R10 pu", pad_pu, 8'h00);
        rd(3'd1, r); check("R10 dir", r, 8'hFF);
        rd(3'd2, r); check("R10 puen", r, 8'h00);
        rd(3'd3, r); check("R10 opt", r, 8'h01);

        // vector table: R1 R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < 6; k++) begin
            wr(3'd1, VEC[k].dir);
            wr(3'd0, VEC[k].lat);
            wr(3'd2, VEC[k].pue);
            wr(3'd3, {7'd0, VEC[k].puoff});
            rst_pin_mode = VEC[k].rstm;
            ext = VEC[k].ext;
            settle();
            check("R1 R4 oe", pad_oe, VEC[k].e_oe);
            check("R3 out", pad_out, VEC[k].lat);
            check("R6 R7 R8 pu", pad_pu, VEC[k].e_pu);
            rd(3'd0, r); check("R2 R5 read", r, VEC[k].e_rd);
            rd(3'd1, r); check("R3 dir readback", r, VEC[k].dir);
        end

        // R2 synchronizer latency
        wr(3'd1, 8'hFF);
        rst_pin_mode = 1'b0;
        ext = 8'h00;
        settle();
        @(negedge clk);
        ext = 8'h3C;
        @(negedge clk);
        rd(3'd0, r); check("R2 first edge old", r, 8'h00);
        @(negedge clk);
        rd(3'd0, r); check("R2 second edge new", r, 8'h3C);

        // R9 read-modify-write folds input pin level into latch
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        ext = 8'hFF;
        settle();
        wr(3'd4, 8'h01);
        check("R9 bset", pad_out, 8'h21);
        settle();
        wr(3'd5, 8'h20);
        check("R9 bclr", pad_out, 8'h01);
        rst_pin_mode = 1'b1;
        settle();
        wr(3'd4, 8'h80);
        check("R9 R5 bset masked", pad_out, 8'h81);

        // R11 unused addresses ignored
        wr(3'd6, 8'h5A);
        wr(3'd7, 8'hFF);
        check("R11 out", pad_out, 8'h81);
        rd(3'd1, r); check("R11 dir", r, 8'h00);
        rd(3'd2, r); check("R11 puen", r, 8'h5A);
        rd(3'd3, r); check("R11 opt", r, 8'h00);

        report();
    end
endmodule